// File: doc/BRIEF.md
# Reservation-Set Wait Stall Controller

This block gives one hart a way to sleep until memory it cares about changes. A load-reserved instruction that retires records a reservation on the naturally aligned 64-byte granule that holds its address. When the pipeline then presents one of the two wait-on-reservation instructions, the block raises a stall and a low-power request. It holds them until something writes into the reserved granule, or an enabled interrupt becomes pending. The short-timeout variant also gives up after a bounded number of cycles.

When the wait ends, the stall and low-power request drop in the same cycle as a one-cycle completion strobe, and that strobe lets the wait instruction retire. If no reservation is held when a wait instruction issues, the instruction completes one cycle later and no stall is raised. Store-conditional retirement, a matching store or snoop, and a taken interrupt all discard the reservation.

Top module: `rsv_wait_top`

## Requirements
- R1: A wait is recognised only when `instValid` is high and `instWord` has bits [6:0]=0x73, bits [11:7]=0, bits [14:12]=0, bits [19:15]=0, and bits [31:20] equal to 0x00D (no-timeout variant) or 0x01D (short-timeout variant). Any other word produces no stall and no completion.
- R2: A retiring load-reserved records the 64-byte granule holding `lrAddr` (address bits above bit 5). A later load-reserved replaces the earlier reservation.
- R3: A wait that issues with no valid reservation raises `waitDone` in the next cycle, and `stall` is never asserted.
- R4: A wait that issues with a valid reservation and no wake condition raises `stall` and `lowPowerReq` from the next cycle. Both stay high on every cycle until a wake condition occurs.
- R5: While stalled, a valid store or snoop whose address falls in the reserved granule ends the wait. In the next cycle `stall` and `lowPowerReq` are low and `waitDone` is high. An address outside the granule leaves the wait unchanged.
- R6: The no-timeout variant has no time bound and remains stalled for any number of cycles without a wake condition.
- R7: The short-timeout variant stays stalled for exactly SHORT_TIMEOUT cycles (default 256) when no other wake condition occurs. The count restarts at zero for every such wait.
- R8: `irqPending` together with `irqEnable` ends a wait, and also completes a wait that issues in the same cycle (with no stall). `irqPending` without `irqEnable` does not wake the hart.
- R9: The reservation is cleared by `scRetire`, by a matching store or snoop (even when no wait is active), and by a taken interrupt (`irqPending` and `irqEnable`). A load-reserved that retires in the same cycle as a clear wins.
- R10: `waitDone` is a single-cycle strobe. `stall` and `lowPowerReq` are low in the cycle it is high.
- R11: A granule match in the same cycle as the short timeout expiring gives one single completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is presented for issue |
| instWord | input | 32 | Instruction word being issued |
| lrRetire | input | 1 | A load-reserved retires this cycle |
| lrAddr | input | ADDR_W | Address of the retiring load-reserved |
| scRetire | input | 1 | A store-conditional retires this cycle |
| storeValid | input | 1 | Local store address is valid |
| storeAddr | input | ADDR_W | Local store address |
| snoopValid | input | 1 | Snooped remote write address is valid |
| snoopAddr | input | ADDR_W | Snooped remote write address |
| irqPending | input | 1 | An interrupt is pending |
| irqEnable | input | 1 | Interrupts are enabled |
| stall | output | 1 | Hold the hart |
| lowPowerReq | output | 1 | Request clock gating while waiting |
| waitDone | output | 1 | One-cycle completion of the wait instruction |

## Verification
Decode is checked by sweeping all 4096 immediates and by flipping each of the lower 20 bits of a valid wait word, which separates true waits from near-miss encodings. Store and snoop addresses are each swept byte by byte across a window that starts below the reserved granule and ends above it. This pins both granule edges exactly and shows that an unaligned load-reserved address still reserves its whole granule. The timing cases cover an unbounded no-timeout wait, the exact stall length of repeated short-timeout waits, and an interrupt without enable, with enable, and at issue. Reservation clearing is checked through whether a later wait stalls, along with the load-reserved priority case and a match landing on the timeout cycle.

// File: rtl/rsv_wait_pkg.sv
package rsv_wait_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } waitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isNto;
    logic isSto;
    logic rsvValid;
    logic rsvHit;
    logic tmoHit;
  } dpStatus_t;

  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] IMM_NTO    = 12'h00D;
  localparam logic [11:0] IMM_STO    = 12'h01D;

endpackage

// File: rtl/rsv_wait_dp.sv
module rsv_wait_dp
  import rsv_wait_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 64,
  parameter int SHORT_TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instWord,
  input  logic              lrRetire,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic              scRetire,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              irqTake,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         status
);

  localparam int OFF_W   = $clog2(GRANULE_BYTES);
  localparam int CNT_W   = $clog2(SHORT_TIMEOUT + 1);
  localparam int NUM_SRC = 2;

  // ---------------- instruction decode ----------------
  logic [6:0]  fOpc;
  logic [4:0]  fRd;
  logic [2:0]  fFunct3;
  logic [4:0]  fRs1;
  logic [11:0] fImm;
  logic        baseMatch;

  assign fOpc      = instWord[6:0];
  assign fRd       = instWord[11:7];
  assign fFunct3   = instWord[14:12];
  assign fRs1      = instWord[19:15];
  assign fImm      = instWord[31:20];
  assign baseMatch = (fOpc == OPC_SYSTEM) && (fRd == '0) && (fFunct3 == '0) && (fRs1 == '0);

  assign status.isNto = baseMatch && (fImm == IMM_NTO);
  assign status.isSto = baseMatch && (fImm == IMM_STO);

  // ---------------- reservation ----------------
  logic              rsvValid;
  logic [ADDR_W-1:0] rsvTag;
  logic [NUM_SRC-1:0]             srcValid;
  logic [NUM_SRC-1:0][ADDR_W-1:0] srcAddr;
  logic [NUM_SRC-1:0]             srcHit;
  logic              rsvHit;

  assign srcValid = {snoopValid, storeValid};
  assign srcAddr  = {snoopAddr, storeAddr};

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrcCmp
    assign srcHit[g] = srcValid[g] && rsvValid && ((srcAddr[g] >> OFF_W) == rsvTag);
  end

  assign rsvHit = |srcHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsvValid <= 1'b0;
      rsvTag   <= '0;
    end else if (lrRetire) begin
      rsvValid <= 1'b1;
      rsvTag   <= lrAddr >> OFF_W;
    end else if (scRetire || rsvHit || irqTake) begin
      rsvValid <= 1'b0;
    end
  end

  // ---------------- short-timeout counter ----------------
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (ctl.cntClear) cnt <= '0;
    else if (ctl.cntInc)   cnt <= cnt + CNT_W'(1);
  end

  assign status.rsvValid = rsvValid;
  assign status.rsvHit   = rsvHit;
  assign status.tmoHit   = (cnt == CNT_W'(SHORT_TIMEOUT - 1));

  // ---------------- assertions ----------------
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(SHORT_TIMEOUT));

  assert_lr_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    lrRetire |=> rsvValid);

  assert_hit_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rsvHit && !lrRetire) |=> !rsvValid);

  assert_sc_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (scRetire && !lrRetire) |=> !rsvValid);

endmodule

// File: rtl/rsv_wait_ctrl.sv
module rsv_wait_ctrl
  import rsv_wait_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic       irqWake,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       stall,
  output logic       lowPowerReq,
  output logic       waitDone
);

  waitState_t state;
  logic       stoQ;
  logic       lpQ;
  logic       doneQ;
  logic       waitIssue;
  logic       wakeNow;

  assign waitIssue = instValid && (status.isNto || status.isSto) && (state == ST_IDLE);
  assign wakeNow   = status.rsvHit || irqWake || (stoQ && status.tmoHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stoQ  <= 1'b0;
      lpQ   <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (waitIssue) begin
            if (!status.rsvValid || status.rsvHit || irqWake) begin
              doneQ <= 1'b1;
            end else begin
              state <= ST_WAIT;
              stoQ  <= status.isSto;
              lpQ   <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (wakeNow) begin
            state <= ST_IDLE;
            lpQ   <= 1'b0;
            doneQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.cntClear = waitIssue;
    ctl.cntInc   = (state == ST_WAIT) && stoQ && !wakeNow;
  end

  assign stall       = (state == ST_WAIT);
  assign lowPowerReq = lpQ;
  assign waitDone    = doneQ;

  // ---------------- assertions ----------------
  assert_lp_with_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> lowPowerReq);

  assert_stall_needs_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(waitIssue));

  assert_no_rsv_R3: assert property (@(posedge clk) disable iff (!rstN)
    (waitIssue && !status.rsvValid) |=> (waitDone && !stall));

  assert_nto_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !stoQ && !status.rsvHit && !irqWake) |=> stall);

  assert_irq_wakes_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && irqWake) |=> (waitDone && !stall));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    waitDone |-> (!stall && !lowPowerReq));

  assert_fall_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> waitDone);

endmodule

// File: rtl/rsv_wait_top.sv
module rsv_wait_top
  import rsv_wait_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 64,
  parameter int SHORT_TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic              lrRetire,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic              scRetire,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              irqPending,
  input  logic              irqEnable,
  output logic              stall,
  output logic              lowPowerReq,
  output logic              waitDone
);

  ctlStrobe_t ctl;
  dpStatus_t  status;
  logic       irqTake;

  assign irqTake = irqPending && irqEnable;

  rsv_wait_dp #(
    .ADDR_W       (ADDR_W),
    .GRANULE_BYTES(GRANULE_BYTES),
    .SHORT_TIMEOUT(SHORT_TIMEOUT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .instWord  (instWord),
    .lrRetire  (lrRetire),
    .lrAddr    (lrAddr),
    .scRetire  (scRetire),
    .storeValid(storeValid),
    .storeAddr (storeAddr),
    .snoopValid(snoopValid),
    .snoopAddr (snoopAddr),
    .irqTake   (irqTake),
    .ctl       (ctl),
    .status    (status)
  );

  rsv_wait_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .irqWake    (irqTake),
    .status     (status),
    .ctl        (ctl),
    .stall      (stall),
    .lowPowerReq(lowPowerReq),
    .waitDone   (waitDone)
  );

endmodule

// File: tb/rsv_wait_top_tb_top.sv
`timescale 1ns/1ps
module rsv_wait_top_tb_top;

  localparam int AW  = 16;
  localparam int TMO = 12;
  localparam logic [31:0] W_NTO = 32'h00D00073;
  localparam logic [31:0] W_STO = 32'h01D00073;

  logic clk = 1'b0;
  logic rstN;
  logic instValid;
  logic [31:0] instWord;
  logic lrRetire;
  logic [AW-1:0] lrAddr;
  logic scRetire;
  logic storeValid;
  logic [AW-1:0] storeAddr;
  logic snoopValid;
  logic [AW-1:0] snoopAddr;
  logic irqPending;
  logic irqEnable;
  logic stall;
  logic lowPowerReq;
  logic waitDone;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rsv_wait_top #(
    .ADDR_W       (AW),
    .GRANULE_BYTES(64),
    .SHORT_TIMEOUT(TMO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .lrRetire(lrRetire), .lrAddr(lrAddr), .scRetire(scRetire),
    .storeValid(storeValid), .storeAddr(storeAddr),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .irqPending(irqPending), .irqEnable(irqEnable),
    .stall(stall), .lowPowerReq(lowPowerReq), .waitDone(waitDone)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doLr(input logic [AW-1:0] a);
    lrRetire = 1'b1; lrAddr = a;
    tick();
    lrRetire = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    instValid = 1'b1; instWord = w;
    tick();
    instValid = 1'b0; instWord = '0;
  endtask

  // wake through an interrupt, land in the completion cycle
  task automatic irqEnd();
    irqPending = 1'b1; irqEnable = 1'b1;
    tick();
    irqPending = 1'b0; irqEnable = 1'b0;
  endtask

  task automatic drvStore(input bit snoop, input logic [AW-1:0] a);
    if (snoop) begin snoopValid = 1'b1; snoopAddr = a; end
    else       begin storeValid = 1'b1; storeAddr = a; end
    tick();
    snoopValid = 1'b0; storeValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instWord = '0; lrRetire = 1'b0; lrAddr = '0;
    scRetire = 1'b0; storeValid = 1'b0; storeAddr = '0; snoopValid = 1'b0;
    snoopAddr = '0; irqPending = 1'b0; irqEnable = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // reset state
    chk("reset stall", stall, 0);
    chk("reset lowPowerReq", lowPowerReq, 0);
    chk("reset waitDone", waitDone, 0);

    // R3: no reservation after reset
    issue(W_NTO);
    chk("R3 done next cycle", waitDone, 1);
    chk("R3 no stall", stall, 0);
    tick();
    chk("R10 done one cycle", waitDone, 0);
    chk("R3 still no stall", stall, 0);

    // R1: full immediate sweep
    for (int i = 0; i < 4096; i++) begin
      bit isW;
      doLr(16'h0400);
      issue({i[11:0], 20'h00073});
      isW = (i == 'h00D) || (i == 'h01D);
      chk($sformatf("R1 imm=%03h stall", i), stall, 32'(isW));
      chk($sformatf("R1 imm=%03h done", i), waitDone, 0);
      if (isW) begin irqEnd(); tick(); end
    end
    // R1: single bit flips of the other fields
    for (int b = 0; b < 20; b++) begin
      doLr(16'h0400);
      issue(W_NTO ^ (32'h1 << b));
      chk($sformatf("R1 flip bit %0d stall", b), stall, 0);
      chk($sformatf("R1 flip bit %0d done", b), waitDone, 0);
    end
    // R1: valid word without instValid
    doLr(16'h0400);
    instWord = W_NTO; tick(); instWord = '0;
    chk("R1 no valid no stall", stall, 0);

    // R5 / R2: store and snoop address sweep around granule 0x1240..0x127F
    for (int s = 0; s < 2; s++) begin
      for (int off = -80; off < 144; off++) begin
        int  a;
        bit  hit;
        a   = 'h1240 + off;
        hit = (a >= 'h1240) && (a <= 'h127F);
        doLr(16'h1245);
        issue(W_NTO);
        chk("R4 stall on wait", stall, 1);
        chk("R4 lowPowerReq on wait", lowPowerReq, 1);
        drvStore(s[0], a[AW-1:0]);
        chk($sformatf("R5 src%0d addr=%04h done", s, a), waitDone, 32'(hit));
        chk($sformatf("R5 src%0d addr=%04h stall", s, a), stall, 32'(!hit));
        if (hit) begin
          chk("R10 lowPowerReq low at done", lowPowerReq, 0);
          tick();
          chk("R10 done single", waitDone, 0);
        end else begin
          irqEnd(); tick();
        end
      end
    end

    // R6: no-timeout wait persists well past the short timeout
    doLr(16'h2000);
    issue(W_NTO);
    for (int k = 0; k < 3 * TMO; k++) begin
      chk("R6 stall persists", stall, 1);
      chk("R4 lowPowerReq persists", lowPowerReq, 1);
      tick();
    end
    irqEnd();
    chk("R8 irq ends nto", waitDone, 1);
    tick();

    // R7: exact short-timeout length, twice
    for (int rep = 0; rep < 2; rep++) begin
      int n;
      n = 0;
      doLr(16'h3010);
      issue(W_STO);
      while (stall && n < 100) begin n++; tick(); end
      chk("R7 stall length", n, TMO);
      chk("R7 done on timeout", waitDone, 1);
      tick();
      chk("R10 done single after timeout", waitDone, 0);
    end

    // R8: pending without enable does not wake
    doLr(16'h4000);
    issue(W_NTO);
    irqPending = 1'b1;
    for (int k = 0; k < 3; k++) begin tick(); chk("R8 masked irq holds", stall, 1); end
    irqEnable = 1'b1;
    tick();
    irqPending = 1'b0; irqEnable = 1'b0;
    chk("R8 enabled irq wakes done", waitDone, 1);
    chk("R8 enabled irq wakes stall", stall, 0);
    tick();
    // R8: interrupt in issue cycle
    doLr(16'h4000);
    irqPending = 1'b1; irqEnable = 1'b1;
    issue(W_NTO);
    irqPending = 1'b0; irqEnable = 1'b0;
    chk("R8 irq at issue done", waitDone, 1);
    chk("R8 irq at issue no stall", stall, 0);
    tick();

    // R9: taken interrupt clears reservation
    doLr(16'h4000);
    irqEnd();
    issue(W_NTO);
    chk("R9 irq cleared rsv", waitDone, 1);
    chk("R9 irq cleared rsv stall", stall, 0);
    tick();
    // R9: store-conditional clears
    doLr(16'h5000);
    scRetire = 1'b1; tick(); scRetire = 1'b0;
    issue(W_NTO);
    chk("R9 sc cleared rsv", waitDone, 1);
    chk("R9 sc cleared rsv stall", stall, 0);
    tick();
    // R9: matching store while idle clears
    doLr(16'h5000);
    drvStore(1'b0, 16'h503F);
    issue(W_NTO);
    chk("R9 idle store cleared rsv", stall, 0);
    chk("R9 idle store cleared done", waitDone, 1);
    tick();
    // R9: non-matching snoop while idle keeps it
    doLr(16'h5000);
    drvStore(1'b1, 16'h5040);
    issue(W_NTO);
    chk("R9 outside snoop keeps rsv", stall, 1);
    irqEnd(); tick();
    // R9: load-reserved wins over same-cycle clear
    scRetire = 1'b1;
    doLr(16'h6000);
    scRetire = 1'b0;
    issue(W_NTO);
    chk("R9 lr beats sc", stall, 1);
    irqEnd(); tick();

    // R2: new reservation replaces old
    doLr(16'h7000);
    doLr(16'h7100);
    issue(W_NTO);
    drvStore(1'b0, 16'h7000);
    chk("R2 old granule ignored stall", stall, 1);
    chk("R2 old granule ignored done", waitDone, 0);
    drvStore(1'b1, 16'h7110);
    chk("R2 new granule wakes", waitDone, 1);
    chk("R2 new granule stall", stall, 0);
    tick();

    // R11: match on the timeout cycle
    doLr(16'h8000);
    issue(W_STO);
    repeat (TMO - 1) tick();
    chk("R11 still stalled at last cycle", stall, 1);
    drvStore(1'b0, 16'h8004);
    chk("R11 single completion done", waitDone, 1);
    chk("R11 stall low", stall, 0);
    tick();
    chk("R11 no second done", waitDone, 0);
    chk("R11 stays idle", stall, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule